// File: doc/BRIEF.md
# Accumulator Memory-Reference Execute Unit

This block carries out the memory-reference instructions of a 16-bit accumulator machine. The machine also has a one-bit link register. Fetch and decode have already happened elsewhere. The block receives an opcode, an indirect flag and an 11-bit address field with a one-cycle `start` strobe. It keeps a private 2048-word memory. When the indirect flag is set, it resolves the effective address through exactly one pointer word. It then updates the accumulator, link, program counter and memory. It finishes with a one-cycle `done` pulse and the number of machine cycles the instruction costs (1, 2 or 3).

A small controller sequences the work through three named states:
- `S_IDLE` waits for `start`. Load-immediate finishes here in a single cycle.
- `S_PTR` reads the pointer word for indirect forms.
- `S_EXEC` reads the operand, writes memory if needed and commits the results.

The transitions are:
- idle→idle on load-immediate.
- idle→ptr on an indirect memory operation.
- idle→exec on a direct memory operation.
- ptr→exec always.
- exec→idle always.

While idle, a plain memory port lets the surrounding logic preload and inspect words.

Top module: `mr_exec_unit`

## Requirements
- R1: `opcode` encoding:
  - 0 load-immediate, 1 jump, 2 deposit, 3 exchange, 4 increment-and-skip, 5 call.
  - 6 AND, 7 OR, 8 XOR, 9 load, 10 add, 11 subtract, 12 skip-if-equal.
  - Codes 13–15 change no register and no memory word, but still take 2 cycles (direct) or 3 cycles (indirect).
- R2: Load-immediate sets the accumulator to the zero-extended address field. With `indirect`=1 it sets the accumulator to the 16-bit two's complement of that field instead. Both forms raise `done` with `cycles`=1 at the first edge after `start`.
- R3: Every other opcode raises `done` for one cycle with `cycles`=2 two edges after `start` when direct, or with `cycles`=3 three edges after `start` when indirect.
- R4: An indirect access reads the word at the address field and uses its low 11 bits as the effective address. Only one level of indirection is applied.
- R5: Add and subtract form the 17-bit sum of the accumulator and either the operand or its 16-bit two's complement. If bit 16 of that sum is set, the link is inverted. The accumulator takes the low 16 bits. No other opcode alters the link.
- R6: Load copies the operand to the accumulator. AND, OR and XOR combine the operand bitwise into the accumulator.
- R7: Deposit writes the accumulator to the effective-address word. Exchange swaps the accumulator and that word.
- R8: Increment-and-skip writes the operand plus one (mod 2^16) back to memory. When the new value is zero, the program counter advances by one.
- R9: Call writes the current program counter (zero-extended) into the effective-address word and sets the program counter to the effective address plus one.
- R10: Jump sets the program counter to the effective address. Skip-if-equal advances the program counter by one only when the accumulator equals the operand.
- R11: The program counter is 11 bits wide and every update wraps modulo 2048.
- R12: Synchronous reset clears the accumulator, link, program counter and `done`.
- R13: While `busy` is 1, `start` and memory-port writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin executing the presented instruction (sampled only when idle) |
| opcode | input | 4 | Operation code, encoding in R1 |
| indirect | input | 1 | Indirect flag |
| addr_field | input | 11 | Address field / immediate |
| acc | output | 16 | Accumulator |
| link | output | 1 | Link bit |
| pc | output | 11 | Program counter |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 2 | Cycle cost of the completed instruction |
| busy | output | 1 | Instruction in progress |
| mem_we | input | 1 | Memory-port write enable (idle only) |
| mem_addr | input | 11 | Memory-port address |
| mem_wdata | input | 16 | Memory-port write data |
| mem_rdata | output | 16 | Word at `mem_addr` while idle |

## Verification
The hardest situation to produce from the ports is a collision with an indirect instruction in flight. Here a second `start` and a memory-port write arrive while the controller is fetching the pointer. The stimulus launches an indirect load and, on the very next cycle, drives both a load-immediate request and a port write. It then checks that the accumulator holds only the indirect result and that the targeted word is untouched. Program-counter wrap at the top of the address space is reached by first jumping to the last word. An increment-and-skip or a call issued from there must then roll over to zero.

// File: rtl/mr_pkg.sv
package mr_pkg;
    typedef enum logic [3:0] {
        OP_LDI  = 4'd0,
        OP_JMP  = 4'd1,
        OP_DEP  = 4'd2,
        OP_XCH  = 4'd3,
        OP_INCS = 4'd4,
        OP_CALL = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_LD   = 4'd9,
        OP_ADD  = 4'd10,
        OP_SUB  = 4'd11,
        OP_SKEQ = 4'd12
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PTR  = 2'd1,
        S_EXEC = 2'd2
    } state_e;
endpackage

// File: rtl/mr_word_ram.sv
module mr_word_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // asynchronous read: the old word is visible during a same-cycle write
    assign rdata = words[addr];

    always_ff @(posedge clk) begin
        if (we) begin
            words[addr] <= wdata;
        end
    end
endmodule

// File: rtl/mr_alu.sv
module mr_alu
    import mr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input  op_e               op,
    input  logic              ind,
    input  logic [ADDR_W-1:0] field,
    input  logic [ADDR_W-1:0] ea,
    input  logic [DATA_W-1:0] acc,
    input  logic              link,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] mword,
    output logic [DATA_W-1:0] acc_n,
    output logic              link_n,
    output logic [ADDR_W-1:0] pc_n,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data
);
    localparam int PAD_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] field_ext;
    logic [DATA_W-1:0] neg_m;
    logic [DATA_W:0]   sum_add;
    logic [DATA_W:0]   sum_sub;
    logic [DATA_W-1:0] inc_m;

    always_comb begin
        field_ext = {{PAD_W{1'b0}}, field};
        neg_m     = ~mword + 1'b1;
        sum_add   = {1'b0, acc} + {1'b0, mword};
        sum_sub   = {1'b0, acc} + {1'b0, neg_m};
        inc_m     = mword + 1'b1;
    end

    always_comb begin
        acc_n   = acc;
        link_n  = link;
        pc_n    = pc;
        wr_en   = 1'b0;
        wr_data = acc;
        unique case (op)
            OP_LDI:  acc_n = ind ? (~field_ext + 1'b1) : field_ext;
            OP_JMP:  pc_n  = ea;
            OP_DEP:  wr_en = 1'b1;
            OP_XCH: begin
                wr_en = 1'b1;
                acc_n = mword;
            end
            OP_INCS: begin
                wr_en   = 1'b1;
                wr_data = inc_m;
                if (inc_m == '0) pc_n = pc + 1'b1;
            end
            OP_CALL: begin
                wr_en   = 1'b1;
                wr_data = {{PAD_W{1'b0}}, pc};
                pc_n    = ea + 1'b1;
            end
            OP_AND:  acc_n = acc & mword;
            OP_OR:   acc_n = acc | mword;
            OP_XOR:  acc_n = acc ^ mword;
            OP_LD:   acc_n = mword;
            OP_ADD: begin
                acc_n  = sum_add[DATA_W-1:0];
                link_n = link ^ sum_add[DATA_W];
            end
            OP_SUB: begin
                acc_n  = sum_sub[DATA_W-1:0];
                link_n = link ^ sum_sub[DATA_W];
            end
            OP_SKEQ: if (acc == mword) pc_n = pc + 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mr_exec_unit.sv
module mr_exec_unit
    import mr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        opcode,
    input  logic              indirect,
    input  logic [ADDR_W-1:0] addr_field,
    output logic [DATA_W-1:0] acc,
    output logic              link,
    output logic [ADDR_W-1:0] pc,
    output logic              done,
    output logic [1:0]        cycles,
    output logic              busy,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] mem_rdata
);
    state_e            state, state_n;
    op_e               op_q;
    logic              ind_q;
    logic [ADDR_W-1:0] field_q;
    logic [ADDR_W-1:0] ea_q;

    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata;

    op_e               alu_op;
    logic              alu_ind;
    logic [ADDR_W-1:0] alu_field;
    logic [DATA_W-1:0] alu_acc;
    logic              alu_link;
    logic [ADDR_W-1:0] alu_pc;
    logic              alu_wr;
    logic [DATA_W-1:0] alu_wdata;

    logic              is_idle;
    logic              launch;
    logic              launch_ldi;

    assign is_idle    = (state == S_IDLE);
    assign launch     = is_idle && start;
    assign launch_ldi = launch && (op_e'(opcode) == OP_LDI);
    assign busy       = !is_idle;

    // memory address / write steering
    always_comb begin
        ram_addr  = mem_addr;
        ram_we    = mem_we;
        ram_wdata = mem_wdata;
        unique case (state)
            S_IDLE: ;
            S_PTR: begin
                ram_addr = field_q;
                ram_we   = 1'b0;
            end
            S_EXEC: begin
                ram_addr  = ea_q;
                ram_we    = alu_wr;
                ram_wdata = alu_wdata;
            end
            default: ram_we = 1'b0;
        endcase
    end

    assign mem_rdata = ram_rdata;

    mr_word_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    assign alu_op    = is_idle ? op_e'(opcode) : op_q;
    assign alu_ind   = is_idle ? indirect      : ind_q;
    assign alu_field = is_idle ? addr_field    : field_q;

    mr_alu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_alu (
        .op      (alu_op),
        .ind     (alu_ind),
        .field   (alu_field),
        .ea      (ea_q),
        .acc     (acc),
        .link    (link),
        .pc      (pc),
        .mword   (ram_rdata),
        .acc_n   (alu_acc),
        .link_n  (alu_link),
        .pc_n    (alu_pc),
        .wr_en   (alu_wr),
        .wr_data (alu_wdata)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: begin
                if (launch && !launch_ldi) begin
                    state_n = indirect ? S_PTR : S_EXEC;
                end
            end
            S_PTR:   state_n = S_EXEC;
            S_EXEC:  state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // state register and captured instruction
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            op_q    <= OP_LDI;
            ind_q   <= 1'b0;
            field_q <= '0;
            ea_q    <= '0;
        end else begin
            state <= state_n;
            if (launch) begin
                op_q    <= op_e'(opcode);
                ind_q   <= indirect;
                field_q <= addr_field;
                ea_q    <= addr_field;
            end else if (state == S_PTR) begin
                ea_q <= ram_rdata[ADDR_W-1:0];
            end
        end
    end

    // architectural registers and completion outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            link   <= 1'b0;
            pc     <= '0;
            done   <= 1'b0;
            cycles <= 2'd0;
        end else begin
            done <= 1'b0;
            if (launch_ldi) begin
                acc    <= alu_acc;
                done   <= 1'b1;
                cycles <= 2'd1;
            end else if (state == S_EXEC) begin
                acc    <= alu_acc;
                link   <= alu_link;
                pc     <= alu_pc;
                done   <= 1'b1;
                cycles <= ind_q ? 2'd3 : 2'd2;
            end
        end
    end
endmodule

// File: rtl/mr_exec_checker.sv
module mr_exec_checker
    import mr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [3:0] opcode,
    input logic       indirect,
    input logic       done,
    input logic [1:0] cycles,
    input logic       busy,
    input logic       link,
    input state_e     state,
    input op_e        op_q
);
    p_ldi_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && opcode == 4'd0) |=> (done && cycles == 2'd1));

    p_direct_cycles_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && opcode != 4'd0 && !indirect)
            |-> ##1 !done ##1 (done && cycles == 2'd2));

    p_indirect_cycles_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && opcode != 4'd0 && indirect)
            |-> ##1 !done ##1 !done ##1 (done && cycles == 2'd3));

    p_done_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_link_only_addsub_r5: assert property (@(posedge clk) disable iff (rst)
        !(state == S_EXEC && (op_q == OP_ADD || op_q == OP_SUB)) |=> $stable(link));
endmodule

bind mr_exec_unit mr_exec_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .opcode   (opcode),
    .indirect (indirect),
    .done     (done),
    .cycles   (cycles),
    .busy     (busy),
    .link     (link),
    .state    (state),
    .op_q     (op_q)
);

// File: tb/mr_exec_unit_tb.sv
module mr_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  opcode;
    logic        indirect;
    logic [10:0] addr_field;
    logic [15:0] acc;
    logic        link;
    logic [10:0] pc;
    logic        done;
    logic [1:0]  cycles;
    logic        busy;
    logic        mem_we;
    logic [10:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    mr_exec_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .indirect(indirect), .addr_field(addr_field), .acc(acc),
        .link(link), .pc(pc), .done(done), .cycles(cycles), .busy(busy),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic        ind;
        logic [10:0] fld;
        logic [15:0] e_acc;
        logic        e_link;
        logic [10:0] e_pc;
        logic [1:0]  e_cyc;
        logic [3:0]  req;
    } vec_t;

    // opcode encoding per R1; each row names its requirement
    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  1'b0, 11'h123, 16'h0123, 1'b0, 11'h000, 2'd1, 4'd2},  // R2
        '{4'd0,  1'b1, 11'h001, 16'hFFFF, 1'b0, 11'h000, 2'd1, 4'd2},  // R2
        '{4'd9,  1'b0, 11'h010, 16'h1234, 1'b0, 11'h000, 2'd2, 4'd6},  // R6
        '{4'd6,  1'b1, 11'h021, 16'h0030, 1'b0, 11'h000, 2'd3, 4'd4},  // R4
        '{4'd7,  1'b0, 11'h011, 16'h00F0, 1'b0, 11'h000, 2'd2, 4'd6},  // R6
        '{4'd8,  1'b0, 11'h010, 16'h12C4, 1'b0, 11'h000, 2'd2, 4'd6},  // R6
        '{4'd10, 1'b0, 11'h040, 16'h92C4, 1'b0, 11'h000, 2'd2, 4'd5},  // R5
        '{4'd10, 1'b0, 11'h040, 16'h12C4, 1'b1, 11'h000, 2'd2, 4'd5},  // R5
        '{4'd11, 1'b1, 11'h020, 16'h0090, 1'b0, 11'h000, 2'd3, 4'd5},  // R5
        '{4'd11, 1'b0, 11'h011, 16'hFFA0, 1'b0, 11'h000, 2'd2, 4'd5},  // R5
        '{4'd12, 1'b0, 11'h030, 16'hFFA0, 1'b0, 11'h000, 2'd2, 4'd10}, // R10
        '{4'd2,  1'b0, 11'h050, 16'hFFA0, 1'b0, 11'h000, 2'd2, 4'd7},  // R7
        '{4'd12, 1'b0, 11'h050, 16'hFFA0, 1'b0, 11'h001, 2'd2, 4'd10}, // R10
        '{4'd4,  1'b0, 11'h030, 16'hFFA0, 1'b0, 11'h002, 2'd2, 4'd8},  // R8
        '{4'd4,  1'b0, 11'h031, 16'hFFA0, 1'b0, 11'h002, 2'd2, 4'd8},  // R8
        '{4'd3,  1'b0, 11'h031, 16'h0006, 1'b0, 11'h002, 2'd2, 4'd7},  // R7
        '{4'd1,  1'b1, 11'h021, 16'h0006, 1'b0, 11'h011, 2'd3, 4'd10}, // R10
        '{4'd5,  1'b0, 11'h060, 16'h0006, 1'b0, 11'h061, 2'd2, 4'd9},  // R9
        '{4'd5,  1'b1, 11'h020, 16'h0006, 1'b0, 11'h011, 2'd3, 4'd9},  // R9
        '{4'd9,  1'b0, 11'h060, 16'h0011, 1'b0, 11'h011, 2'd2, 4'd6},  // R6
        '{4'd9,  1'b1, 11'h020, 16'h0061, 1'b0, 11'h011, 2'd3, 4'd4}   // R4
    };

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic mem_write(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        mem_we = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic mem_read(input logic [10:0] a, output logic [15:0] d);
        @(negedge clk);
        mem_addr = a;
        #1 d = mem_rdata;
    endtask

    // issues one instruction; returns the edge count until done is seen
    task automatic run_op(input logic [3:0] o, input logic i,
                          input logic [10:0] a, output int lat);
        @(negedge clk);
        start = 1'b1; opcode = o; indirect = i; addr_field = a;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 10) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL all: watchdog expired, actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        int lat;
        logic [15:0] rd;
        rst = 1'b1; start = 1'b0; opcode = '0; indirect = 1'b0;
        addr_field = '0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "reset acc/link/pc/done", {acc, link, pc, done},
              {16'h0000, 1'b0, 11'h000, 1'b0});
        rst = 1'b0;

        mem_write(11'h010, 16'h1234);
        mem_write(11'h011, 16'h00F0);
        mem_write(11'h020, 16'h0010);
        mem_write(11'h021, 16'hF811);
        mem_write(11'h030, 16'hFFFF);
        mem_write(11'h031, 16'h0005);
        mem_write(11'h040, 16'h8000);
        mem_write(11'h070, 16'h0000);

        for (int k = 0; k < NV; k++) begin
            run_op(VECS[k].op, VECS[k].ind, VECS[k].fld, lat);
            check($sformatf("R%0d", VECS[k].req),
                  $sformatf("row %0d acc/link/pc/cycles/latency", k),
                  {acc, link, pc, cycles, 4'(lat)},
                  {VECS[k].e_acc, VECS[k].e_link, VECS[k].e_pc,
                   VECS[k].e_cyc, 4'(VECS[k].e_cyc)});
        end

        mem_read(11'h030, rd); check("R8", "incremented word wrapped", 64'(rd), 64'h0000);
        mem_read(11'h031, rd); check("R7", "exchanged word", 64'(rd), 64'hFFA0);
        mem_read(11'h050, rd); check("R7", "deposited word", 64'(rd), 64'hFFA0);
        mem_read(11'h060, rd); check("R9", "direct call return word", 64'(rd), 64'h0011);
        mem_read(11'h010, rd); check("R9", "indirect call return word", 64'(rd), 64'h0061);

        // R13: start and port write while an indirect op is in flight
        @(negedge clk);
        start = 1'b1; opcode = 4'd9; indirect = 1'b1; addr_field = 11'h021;
        @(negedge clk);
        start = 1'b1; opcode = 4'd0; indirect = 1'b0; addr_field = 11'h555;
        mem_we = 1'b1; mem_addr = 11'h070; mem_wdata = 16'hAAAA;
        @(negedge clk);
        start = 1'b0; mem_we = 1'b0;
        repeat (3) @(negedge clk);
        check("R13", "acc after ignored start", {48'd0, acc}, 64'h00F0);
        mem_read(11'h070, rd);
        check("R13", "word after ignored port write", 64'(rd), 64'h0000);

        // R1: unused code changes nothing, indirect costs 3
        run_op(4'd13, 1'b1, 11'h020, lat);
        check("R1", "unused opcode acc/link/pc/cycles",
              {acc, link, pc, cycles}, {16'h00F0, 1'b0, 11'h011, 2'd3});
        mem_read(11'h020, rd);
        check("R1", "unused opcode leaves memory", 64'(rd), 64'h0010);

        // R11: increment-and-skip from the last word wraps pc to zero
        mem_write(11'h030, 16'hFFFF);
        run_op(4'd1, 1'b0, 11'h7FF, lat);
        check("R11", "jump to top", 64'(pc), 64'h7FF);
        run_op(4'd4, 1'b0, 11'h030, lat);
        check("R11", "skip wraps pc", 64'(pc), 64'h000);
        // R11: call at the last word wraps the return target
        run_op(4'd1, 1'b0, 11'h7FF, lat);
        run_op(4'd5, 1'b0, 11'h7FF, lat);
        check("R11", "call target wraps pc", 64'(pc), 64'h000);
        mem_read(11'h7FF, rd);
        check("R9", "call stored pc at top word", 64'(rd), 64'h07FF);

        // R12: reset after activity
        run_op(4'd10, 1'b0, 11'h040, lat);
        run_op(4'd10, 1'b0, 11'h040, lat);
        check("R5", "link inverted before reset", 64'(link), 64'h1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R12", "reset clears acc/link/pc/done", {acc, link, pc, done},
              {16'h0000, 1'b0, 11'h000, 1'b0});

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule